// File: doc/BRIEF.md
# Speculative Load Ordering Checker

This block sits beside the load/store unit of an out-of-order core that lets loads execute before older stores have resolved their addresses. No dependence is assumed when such a load runs. Each load that finishes this way is written into a small buffer with its address and a wrapping age tag. The entry stays there until the load completes and the core releases it by tag.

When a store completes, its address and age are compared in one cycle against every buffered load. A buffered load with the same address that is younger than the store read stale data and must be squashed and reissued. When several loads conflict, the block reports the oldest of them, because the recovery restarts from that load and discards all later work. If no load conflicts, nothing is reported and the store completes normally. A flush input empties the buffer. A full flag tells the issue logic to stop issuing loads speculatively.

Top module: `ld_alias_chk`

## Requirements
- R1: During and right after reset the buffer is empty: `full_o` and `squash_valid_o` are 0.
- R2: An insert stores one load in the lowest free entry. With 8 entries, `full_o` reads 1 in the cycle after the eighth insert.
- R3: An insert while `full_o` is 1 is dropped. A later store to that load's address and older than it raises no squash, and the buffer stays full.
- R4: A release whose age equals a buffered load's age frees that entry. The freed load can no longer trigger a squash, and `full_o` falls in the next cycle.
- R5: A store check that matches the address of a buffered load younger than the store sets `squash_valid_o` in the next cycle, with `squash_age_o` equal to that load's age.
- R6: A buffered load with the same address whose age is equal to or older than the store's age raises no squash.
- R7: A buffered load at a different address raises no squash.
- R8: When several buffered loads conflict with one store, `squash_age_o` gives the oldest of them.
- R9: Age order is modular over the 6-bit tag. Load age L is younger than store age S when (L-S) mod 64 lies in 1..31. For example, load 1 is younger than store 62, and load 1 is older than store 3.
- R10: `flush_i` empties the buffer. In the next cycle `full_o` and `squash_valid_o` are 0, and a store check that was active during the flush reports nothing.
- R11: A store check compares only against loads held at the start of its cycle. A load inserted in the same cycle is not flagged, but it is flagged by a later check.
- R12: `squash_valid_o` is a one-cycle pulse. It is raised only in the cycle after an active store check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clears every buffered load |
| ld_ins_valid_i | input | 1 | A load finished speculatively |
| ld_ins_addr_i | input | 16 | Address of the finished load |
| ld_ins_age_i | input | 6 | Age tag of the finished load |
| ld_rel_valid_i | input | 1 | A load has completed |
| ld_rel_age_i | input | 6 | Age tag of the completed load |
| st_chk_valid_i | input | 1 | A store reached completion |
| st_chk_addr_i | input | 16 | Address of the completing store |
| st_chk_age_i | input | 6 | Age tag of the completing store |
| full_o | output | 1 | Every entry is occupied; stop speculative load issue |
| squash_valid_o | output | 1 | An ordering violation was found |
| squash_age_o | output | 6 | Age of the oldest violating load |

## Verification
The store check is driven with the same address against younger, equal-aged and older loads, so that an address match alone is told apart from a real ordering violation. It is also driven with a foreign address and with two conflicting loads, which shows whether the oldest one is selected. Tags on both sides of the wrap point separate modular age comparison from plain magnitude comparison. Directed sequences then cover filling the buffer, a dropped insert while full, release, flush against a check in the same cycle, and an insert in the same cycle as a check.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  localparam int unsigned LDQ_ENTRIES = 8;
  localparam int unsigned LDQ_ADDR_W  = 16;
  localparam int unsigned LDQ_AGE_W   = 6;

  // a younger than b under modular tag order of width w
  function automatic logic age_younger(input logic [31:0] a, input logic [31:0] b,
                                       input int unsigned w);
    logic [31:0] mask, diff;
    mask = (32'd1 << w) - 32'd1;
    diff = (a - b) & mask;
    return (diff != 32'd0) && (diff < (32'd1 << (w - 1)));
  endfunction
endpackage

// File: rtl/ldq_slot.sv
module ldq_slot #(
  parameter int unsigned ADDR_W = ldq_pkg::LDQ_ADDR_W,
  parameter int unsigned AGE_W  = ldq_pkg::LDQ_AGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic [AGE_W-1:0]  set_age_i,
  input  logic              rel_i,
  input  logic [AGE_W-1:0]  rel_age_i,
  input  logic              chk_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [AGE_W-1:0]  chk_age_i,
  output logic              valid_o,
  output logic [AGE_W-1:0]  age_o,
  output logic              hit_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AGE_W-1:0]  age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      age_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      addr_q  <= set_addr_i;
      age_q   <= set_age_i;
    end else if (rel_i && valid_q && (age_q == rel_age_i)) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign age_o   = age_q;
  assign hit_o   = valid_q && chk_i && (addr_q == chk_addr_i) &&
                   ldq_pkg::age_younger(32'(age_q), 32'(chk_age_i), AGE_W);

  // R2
  slot_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !flush_i |=> valid_o && (age_o == $past(set_age_i)));
endmodule

// File: rtl/ldq_free_pick.sv
module ldq_free_pick #(
  parameter int unsigned N = ldq_pkg::LDQ_ENTRIES
) (
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] gnt_o,
  output logic         full_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) gnt_o = N'(1) << i;
    end
  end
  assign full_o = &valid_i;
endmodule

// File: rtl/ldq_oldest_pick.sv
module ldq_oldest_pick #(
  parameter int unsigned N     = ldq_pkg::LDQ_ENTRIES,
  parameter int unsigned AGE_W = ldq_pkg::LDQ_AGE_W
) (
  input  logic [N-1:0]            hit_i,
  input  logic [N-1:0][AGE_W-1:0] age_i,
  output logic                    found_o,
  output logic [AGE_W-1:0]        age_o
);
  always_comb begin
    found_o = 1'b0;
    age_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i] && (!found_o ||
          ldq_pkg::age_younger(32'(age_o), 32'(age_i[i]), AGE_W))) begin
        found_o = 1'b1;
        age_o   = age_i[i];
      end
    end
  end
endmodule

// File: rtl/ld_alias_chk.sv
module ld_alias_chk #(
  parameter int unsigned ENTRIES = ldq_pkg::LDQ_ENTRIES,
  parameter int unsigned ADDR_W  = ldq_pkg::LDQ_ADDR_W,
  parameter int unsigned AGE_W   = ldq_pkg::LDQ_AGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ld_ins_valid_i,
  input  logic [ADDR_W-1:0] ld_ins_addr_i,
  input  logic [AGE_W-1:0]  ld_ins_age_i,
  input  logic              ld_rel_valid_i,
  input  logic [AGE_W-1:0]  ld_rel_age_i,
  input  logic              st_chk_valid_i,
  input  logic [ADDR_W-1:0] st_chk_addr_i,
  input  logic [AGE_W-1:0]  st_chk_age_i,
  output logic              full_o,
  output logic              squash_valid_o,
  output logic [AGE_W-1:0]  squash_age_o
);
  logic [ENTRIES-1:0]            slot_valid, slot_gnt, slot_hit;
  logic [ENTRIES-1:0][AGE_W-1:0] slot_age;
  logic                          buf_full, insert, found;
  logic [AGE_W-1:0]              found_age;
  logic                          sq_valid_q;
  logic [AGE_W-1:0]              sq_age_q;

  ldq_free_pick #(.N(ENTRIES)) i_free (
    .valid_i(slot_valid),
    .gnt_o  (slot_gnt),
    .full_o (buf_full)
  );

  assign insert = ld_ins_valid_i && !buf_full && !flush_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    ldq_slot #(.ADDR_W(ADDR_W), .AGE_W(AGE_W)) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .set_i     (insert && slot_gnt[g]),
      .set_addr_i(ld_ins_addr_i),
      .set_age_i (ld_ins_age_i),
      .rel_i     (ld_rel_valid_i),
      .rel_age_i (ld_rel_age_i),
      .chk_i     (st_chk_valid_i),
      .chk_addr_i(st_chk_addr_i),
      .chk_age_i (st_chk_age_i),
      .valid_o   (slot_valid[g]),
      .age_o     (slot_age[g]),
      .hit_o     (slot_hit[g])
    );
  end

  ldq_oldest_pick #(.N(ENTRIES), .AGE_W(AGE_W)) i_oldest (
    .hit_i  (slot_hit),
    .age_i  (slot_age),
    .found_o(found),
    .age_o  (found_age)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_valid_q <= 1'b0;
      sq_age_q   <= '0;
    end else begin
      sq_valid_q <= found && !flush_i;
      sq_age_q   <= found_age;
    end
  end

  assign full_o         = buf_full;
  assign squash_valid_o = sq_valid_q;
  assign squash_age_o   = sq_age_q;

  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !full_o && !squash_valid_o);

  // R12
  squash_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_o |-> $past(st_chk_valid_i) && !$past(flush_i));

  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !ld_rel_valid_i && !flush_i |=> full_o);

  // R4
  rel_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o && !ld_ins_valid_i |=> !full_o);
endmodule

// File: tb/test_ld_alias_chk.sv
module test_ld_alias_chk;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        ins_v = 1'b0, rel_v = 1'b0, chk_v = 1'b0;
  logic [15:0] ins_addr = '0, chk_addr = '0;
  logic [5:0]  ins_age = '0, rel_age = '0, chk_age = '0;
  logic        full, sq_v;
  logic [5:0]  sq_age;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ld_alias_chk i_ld_alias_chk (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ld_ins_valid_i(ins_v), .ld_ins_addr_i(ins_addr), .ld_ins_age_i(ins_age),
    .ld_rel_valid_i(rel_v), .ld_rel_age_i(rel_age),
    .st_chk_valid_i(chk_v), .st_chk_addr_i(chk_addr), .st_chk_age_i(chk_age),
    .full_o(full), .squash_valid_o(sq_v), .squash_age_o(sq_age)
  );

  typedef struct packed {
    logic [2:0]  op;   // 0 idle, 1 insert, 2 release, 3 check, 4 flush
    logic [15:0] addr;
    logic [5:0]  age;
    logic        esq;
    logic [5:0]  eage;
    logic        efull;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 16'h0100, 6'd5,  1'b0, 6'd0, 1'b0},  // R2 insert
    '{3'd1, 16'h0200, 6'd6,  1'b0, 6'd0, 1'b0},  // R2
    '{3'd1, 16'h0100, 6'd8,  1'b0, 6'd0, 1'b0},  // R2
    '{3'd3, 16'h0100, 6'd4,  1'b1, 6'd5, 1'b0},  // R8 two hits, oldest 5
    '{3'd0, 16'h0000, 6'd0,  1'b0, 6'd0, 1'b0},  // R12 pulse ends
    '{3'd3, 16'h0100, 6'd5,  1'b1, 6'd8, 1'b0},  // R6 equal age skipped, R5 hit 8
    '{3'd3, 16'h0100, 6'd9,  1'b0, 6'd0, 1'b0},  // R6 all older
    '{3'd3, 16'h0300, 6'd0,  1'b0, 6'd0, 1'b0},  // R7 other address
    '{3'd3, 16'h0200, 6'd2,  1'b1, 6'd6, 1'b0},  // R5
    '{3'd2, 16'h0000, 6'd5,  1'b0, 6'd0, 1'b0},  // R4 release 5
    '{3'd3, 16'h0100, 6'd4,  1'b1, 6'd8, 1'b0},  // R4 only 8 left
    '{3'd4, 16'h0000, 6'd0,  1'b0, 6'd0, 1'b0},  // R10 flush
    '{3'd3, 16'h0200, 6'd2,  1'b0, 6'd0, 1'b0},  // R10 emptied
    '{3'd1, 16'h0040, 6'd1,  1'b0, 6'd0, 1'b0},  // R9 setup
    '{3'd3, 16'h0040, 6'd62, 1'b1, 6'd1, 1'b0},  // R9 wrap, 1 younger than 62
    '{3'd3, 16'h0040, 6'd3,  1'b0, 6'd0, 1'b0}   // R9 1 older than 3
  };

  task automatic idle_in();
    ins_v = 1'b0; rel_v = 1'b0; chk_v = 1'b0; flush = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic esq, input logic [5:0] eage,
                            input logic efull);
    checks++;
    if (sq_v !== esq || (esq && sq_age !== eage) || full !== efull) begin
      failures++;
      $display("FAIL %s: got sq=%0b age=%0d full=%0b, want sq=%0b age=%0d full=%0b",
               req, sq_v, sq_age, full, esq, eage, efull);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hang, want completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    expect_out("R1 in reset", 1'b0, 6'd0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step();
    expect_out("R1 after reset", 1'b0, 6'd0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idle_in();
      case (TBL[v].op)
        3'd1: begin ins_v = 1'b1; ins_addr = TBL[v].addr; ins_age = TBL[v].age; end
        3'd2: begin rel_v = 1'b1; rel_age = TBL[v].age; end
        3'd3: begin chk_v = 1'b1; chk_addr = TBL[v].addr; chk_age = TBL[v].age; end
        3'd4: flush = 1'b1;
        default: ;
      endcase
      step();
      expect_out($sformatf("table row %0d", v), TBL[v].esq, TBL[v].eage, TBL[v].efull);
    end

    // R10: flush beats a conflicting check in the same cycle
    @(negedge clk); idle_in();
    chk_v = 1'b1; chk_addr = 16'h0040; chk_age = 6'd62; flush = 1'b1;
    step();
    expect_out("R10 flush with check", 1'b0, 6'd0, 1'b0);

    // R2: fill all 8 entries
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); idle_in();
      ins_v = 1'b1; ins_addr = 16'h0500 + 16'(k); ins_age = 6'(10 + k);
      step();
      if (k == 6) expect_out("R2 seven held", 1'b0, 6'd0, 1'b0);
    end
    expect_out("R2 full after eight", 1'b0, 6'd0, 1'b1);

    // R3: insert while full is dropped
    @(negedge clk); idle_in();
    ins_v = 1'b1; ins_addr = 16'h0777; ins_age = 6'd20;
    step();
    expect_out("R3 still full", 1'b0, 6'd0, 1'b1);
    @(negedge clk); idle_in();
    chk_v = 1'b1; chk_addr = 16'h0777; chk_age = 6'd19;
    step();
    expect_out("R3 dropped load not flagged", 1'b0, 6'd0, 1'b1);

    // R4: release frees an entry
    @(negedge clk); idle_in();
    rel_v = 1'b1; rel_age = 6'd10;
    step();
    expect_out("R4 full drops", 1'b0, 6'd0, 1'b0);
    @(negedge clk); idle_in();
    chk_v = 1'b1; chk_addr = 16'h0500; chk_age = 6'd9;
    step();
    expect_out("R4 released load not flagged", 1'b0, 6'd0, 1'b0);

    // R11: same-cycle insert not seen by check, later check sees it
    @(negedge clk); idle_in();
    ins_v = 1'b1; ins_addr = 16'h0888; ins_age = 6'd30;
    chk_v = 1'b1; chk_addr = 16'h0888; chk_age = 6'd29;
    step();
    expect_out("R11 same cycle", 1'b0, 6'd0, 1'b1);
    @(negedge clk); idle_in();
    chk_v = 1'b1; chk_addr = 16'h0888; chk_age = 6'd29;
    step();
    expect_out("R11 next check", 1'b1, 6'd30, 1'b1);
    @(negedge clk); idle_in();
    step();
    expect_out("R12 pulse", 1'b0, 6'd0, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule